// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Sensing

This block is a 32-pin general-purpose I/O port. Software reaches it through a small memory-mapped register bus, which has a one-cycle write strobe and a one-cycle read strobe. The port drives an output value and an output enable for each pad. It samples each pad input through a two-flop synchronizer and reports the synchronized value through a read-only register.

Each pin can raise an interrupt. A two-bit field picks how the pin is sensed: low level, high level, rising edge or falling edge. A detection sets a sticky status bit whatever the mask holds. The mask then decides which status bits reach the two request lines. One line serves the lower sixteen pins and the other serves the upper sixteen. Software clears a status bit by writing 1 to it.

Top module: `gpio_sense_port`

## Requirements
- R1: After reset, the data, direction, both sense-configuration and mask registers read 0. `pad_oe_o` and `pad_out_o` are all 0, so every pin is an input. Both interrupt lines are low.
- R2: The registers sit at these byte offsets: data 0x00, direction 0x04, pad status 0x08, sense config for pins 0–15 at 0x0C, sense config for pins 16–31 at 0x10, mask 0x14, status 0x18. Pin n uses bit n. Read data is presented in the cycle after the read strobe.
- R3: `pad_out_o` equals the data register. A direction bit of 1 sets the matching bit of `pad_oe_o` (output), and 0 clears it (input).
- R4: The pad status register returns the pad inputs after a two-flop synchronizer. A status bit is set on the third clock edge after its pad changes.
- R5: Pin n takes its two-bit sense field at bit position 2*(n mod 16). The field is in the low config register for n < 16 and in the high config register otherwise. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge.
- R6: In a level mode the status bit is set on every cycle that the active level lasts. A clear issued while the level is still active does not hold.
- R7: In an edge mode only the selected transition sets the status bit. A stable input and the opposite transition leave it alone.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves the bit as it was.
- R9: Status bits set whatever value the mask holds. A status bit drives an interrupt line only while its mask bit is 1.
- R10: `irq_lo_o` is the OR of (status AND mask) over bits 15:0. `irq_hi_o` is the same OR over bits 31:16.
- R11: When a write-1 clear and a new detection reach the same status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Register byte offset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| pad_in_i | input | 32 | Asynchronous pad inputs |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables, 1 = drive |
| irq_lo_o | output | 1 | Interrupt request for pins 0–15 |
| irq_hi_o | output | 1 | Interrupt request for pins 16–31 |

## Verification
The assertions assume three things about the inputs. The strobes and address are stable around the clock edge. The pads are held long enough to pass the synchronizer. A status write is meant as a clear mask and is never a plain store. The stimulus drives every bus and pad input on the falling edge. It holds each pad pattern for at least four cycles before it samples or clears, except in the cases that aim a clear at the exact cycle of a detection. It samples outputs on the falling edge only. The sense configuration resets to low-level mode, so pins held low set their status bits just after reset. For that reason the stimulus always clears status after it settles the pads and before it judges any result.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_FALL = 2'b11
  } sense_e;

  localparam int unsigned REG_ADDR_W = 5;

  localparam logic [REG_ADDR_W-1:0] OFS_DATA   = 5'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_DIR    = 5'h04;
  localparam logic [REG_ADDR_W-1:0] OFS_PAD    = 5'h08;
  localparam logic [REG_ADDR_W-1:0] OFS_CFG_LO = 5'h0C;
  localparam logic [REG_ADDR_W-1:0] OFS_CFG_HI = 5'h10;
  localparam logic [REG_ADDR_W-1:0] OFS_MASK   = 5'h14;
  localparam logic [REG_ADDR_W-1:0] OFS_STAT   = 5'h18;

endpackage

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
  import gpio_sense_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = REG_ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_sync_i,
  input  logic [NUM_PINS-1:0] status_i,
  output logic [NUM_PINS-1:0] data_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] cfg_lo_o,
  output logic [NUM_PINS-1:0] cfg_hi_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] st_clr_o
);

  logic [NUM_PINS-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q;
  logic [NUM_PINS-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        OFS_DATA:   data_q   <= wdata_i;
        OFS_DIR:    dir_q    <= wdata_i;
        OFS_CFG_LO: cfg_lo_q <= wdata_i;
        OFS_CFG_HI: cfg_hi_q <= wdata_i;
        OFS_MASK:   mask_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  // status writes become a one-cycle clear vector
  assign st_clr_o = (wr_en_i && addr_i == OFS_STAT) ? wdata_i : '0;

  always_comb begin
    unique case (addr_i)
      OFS_DATA:   rd_mux = data_q;
      OFS_DIR:    rd_mux = dir_q;
      OFS_PAD:    rd_mux = pad_sync_i;
      OFS_CFG_LO: rd_mux = cfg_lo_q;
      OFS_CFG_HI: rd_mux = cfg_hi_q;
      OFS_MASK:   rd_mux = mask_q;
      OFS_STAT:   rd_mux = status_i;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign data_o   = data_q;
  assign dir_o    = dir_q;
  assign cfg_lo_o = cfg_lo_q;
  assign cfg_hi_o = cfg_hi_q;
  assign mask_o   = mask_q;

  // R3
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_DIR) |=> (dir_o == $past(wdata_i)));

  // R2
  read_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_MASK && !wr_en_i) |=> (rdata_o == mask_o));

endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
  import gpio_sense_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pad_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  output logic       sync_o,
  output logic       st_o
);

  logic s1_q, s2_q, dly_q, st_q;
  logic det;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      dly_q <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      s1_q  <= pad_i;
      s2_q  <= s1_q;
      dly_q <= s2_q;
      // detection overrides a same-cycle clear
      st_q  <= (st_q & ~clr_i) | det;
    end
  end

  always_comb begin
    unique case (sense_e'(mode_i))
      SENSE_LOW:  det = ~s2_q;
      SENSE_HIGH: det = s2_q;
      SENSE_RISE: det = s2_q & ~dly_q;
      SENSE_FALL: det = ~s2_q & dly_q;
      default:    det = 1'b0;
    endcase
  end

  assign sync_o = s2_q;
  assign st_o   = st_q;

  // R8
  st_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q && !clr_i) |=> st_q);

  // R11
  det_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && det) |=> st_q);

  // R6
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_HIGH && s2_q) |=> st_q);

  // R7
  edge_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && (s2_q == dly_q) && clr_i) |=> !st_q);

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int unsigned NUM_PINS = 32,
  localparam int unsigned HALF    = NUM_PINS / 2
) (
  input  logic [NUM_PINS-1:0] status_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic                irq_lo_o,
  output logic                irq_hi_o
);

  logic [NUM_PINS-1:0] pend;

  assign pend     = status_i & mask_i;
  assign irq_lo_o = |pend[HALF-1:0];
  assign irq_hi_o = |pend[NUM_PINS-1:HALF];

  // R9
  always_comb begin
    if (mask_i == '0) begin
      mask_gate_chk: assert (!irq_lo_o && !irq_hi_o);
    end
  end

endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port
  import gpio_sense_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = REG_ADDR_W,
  localparam int unsigned HALF    = NUM_PINS / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_lo_o,
  output logic                irq_hi_o
);

  logic [NUM_PINS-1:0] pad_sync, status, st_clr;
  logic [NUM_PINS-1:0] data_q, dir_q, cfg_lo, cfg_hi, mask_q;

  gpio_bus_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i, .rdata_o,
    .pad_sync_i (pad_sync),
    .status_i   (status),
    .data_o     (data_q),
    .dir_o      (dir_q),
    .cfg_lo_o   (cfg_lo),
    .cfg_hi_o   (cfg_hi),
    .mask_o     (mask_q),
    .st_clr_o   (st_clr)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [1:0] mode;
    if (i < HALF) begin : g_lo
      assign mode = cfg_lo[2*i +: 2];
    end else begin : g_hi
      assign mode = cfg_hi[2*(i-HALF) +: 2];
    end

    gpio_pin_sense u_pin (
      .clk_i, .rst_ni,
      .pad_i  (pad_in_i[i]),
      .mode_i (mode),
      .clr_i  (st_clr[i]),
      .sync_o (pad_sync[i]),
      .st_o   (status[i])
    );
  end

  gpio_irq_merge #(.NUM_PINS(NUM_PINS)) u_irq (
    .status_i (status),
    .mask_i   (mask_q),
    .irq_lo_o,
    .irq_hi_o
  );

  assign pad_out_o = data_q;
  assign pad_oe_o  = dir_q;

  // R10
  irq_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status[HALF-1:0] & mask_q[HALF-1:0]) == '0) |-> !irq_lo_o);

endmodule

// File: tb/sim_gpio_sense_port.sv
module sim_gpio_sense_port;
  import gpio_sense_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata, pad_in = '0, pad_out, pad_oe;
  logic        irq_lo, irq_hi;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_sense_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  // {cfg_lo, cfg_hi, pad_before, pad_after}
  localparam logic [127:0] VEC [6] = '{
    {32'h5555_5555, 32'h5555_5555, 32'h0000_FFFF, 32'h00FF_00FF},
    {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0F0F_0F0F},
    {32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'h0000_0000, 32'hF00F_0001},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0F0F_0F0F},
    {32'hE4E4_E4E4, 32'hE4E4_E4E4, 32'h3333_3333, 32'h5555_5555},
    {32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_0000}
  };

  function automatic logic [31:0] model_st(logic [31:0] cl, ch, b, a);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] m;
      m = (i < 16) ? cl[2*i +: 2] : ch[2*(i-16) +: 2];
      case (m)
        2'b00:   r[i] = !b[i] || !a[i];
        2'b01:   r[i] = b[i] || a[i];
        2'b10:   r[i] = !b[i] && a[i];
        default: r[i] = b[i] && !a[i];
      endcase
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [4:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [4:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
    check("R1 irq", {30'd0, irq_hi, irq_lo}, '0);
    bus_rd(OFS_DATA, v);   check("R1 data", v, '0);
    bus_rd(OFS_DIR, v);    check("R1 dir", v, '0);
    bus_rd(OFS_CFG_LO, v); check("R1 cfg_lo", v, '0);
    bus_rd(OFS_CFG_HI, v); check("R1 cfg_hi", v, '0);
    bus_rd(OFS_MASK, v);   check("R1 mask", v, '0);

    // R2 R3 data and direction
    bus_wr(OFS_DATA, 32'hA5A5_0F0F);
    check("R3 pad_out", pad_out, 32'hA5A5_0F0F);
    bus_wr(OFS_DIR, 32'hFFFF_0000);
    check("R3 pad_oe", pad_oe, 32'hFFFF_0000);
    bus_rd(OFS_DATA, v); check("R2 data readback", v, 32'hA5A5_0F0F);
    bus_rd(OFS_DIR, v);  check("R2 dir readback", v, 32'hFFFF_0000);

    // R4 pad status
    pad_in = 32'h1234_5678;
    bus_rd(OFS_PAD, v); check("R4 pad not yet synced", v, 32'h0000_0000);
    settle();
    bus_rd(OFS_PAD, v); check("R4 pad synced", v, 32'h1234_5678);

    // R5 R6 R7 vector table
    foreach (VEC[k]) begin
      logic [31:0] cl, ch, b, a;
      {cl, ch, b, a} = VEC[k];
      bus_wr(OFS_CFG_LO, cl);
      bus_wr(OFS_CFG_HI, ch);
      pad_in = b;
      settle();
      bus_wr(OFS_STAT, 32'hFFFF_FFFF);
      settle();
      pad_in = a;
      settle();
      bus_rd(OFS_STAT, v);
      check($sformatf("R5/R6/R7 vector %0d", k), v, model_st(cl, ch, b, a));
    end

    // R8 write-1 clear, write-0 no effect (all rising edge)
    bus_wr(OFS_CFG_LO, 32'hAAAA_AAAA);
    bus_wr(OFS_CFG_HI, 32'hAAAA_AAAA);
    pad_in = '0;
    settle();
    bus_wr(OFS_STAT, 32'hFFFF_FFFF);
    pad_in = 32'h0000_00FF;
    settle();
    bus_rd(OFS_STAT, v); check("R7 rise sets", v, 32'h0000_00FF);
    bus_wr(OFS_STAT, 32'h0000_000F);
    bus_rd(OFS_STAT, v); check("R8 partial clear", v, 32'h0000_00F0);
    bus_wr(OFS_STAT, 32'h0000_0000);
    bus_rd(OFS_STAT, v); check("R8 write zero", v, 32'h0000_00F0);

    // R9 R10 mask gating and half split
    check("R9 masked off", {30'd0, irq_hi, irq_lo}, '0);
    bus_wr(OFS_MASK, 32'h0000_0010);
    check("R10 irq_lo on", {30'd0, irq_hi, irq_lo}, 32'd1);
    bus_wr(OFS_MASK, 32'h0010_0000);
    check("R10 hi mask, no hi status", {30'd0, irq_hi, irq_lo}, '0);
    pad_in = 32'h0010_00FF;
    settle();
    check("R10 irq_hi on", {30'd0, irq_hi, irq_lo}, 32'd2);
    bus_wr(OFS_STAT, 32'h0010_0000);
    check("R8 clear drops irq_hi", {30'd0, irq_hi, irq_lo}, '0);
    bus_wr(OFS_MASK, '0);

    // R6 level-high clear does not hold while active
    bus_wr(OFS_CFG_LO, 32'h0000_0001);
    pad_in = 32'h0000_0001;
    settle();
    bus_wr(OFS_STAT, 32'h0000_0001);
    bus_rd(OFS_STAT, v); check("R6 level re-sets", v & 32'h1, 32'h1);
    pad_in = '0;
    settle();
    bus_wr(OFS_STAT, 32'h0000_0001);
    bus_rd(OFS_STAT, v); check("R6 inactive clears", v & 32'h1, 32'h0);

    // R11 clear lands on detection cycle (pin 1 rising)
    bus_wr(OFS_CFG_LO, 32'h0000_0008);
    settle();
    bus_wr(OFS_STAT, 32'hFFFF_FFFF);
    pad_in = 32'h0000_0002;
    @(negedge clk);
    @(negedge clk);
    bus_wr(OFS_STAT, 32'h0000_0002);
    bus_rd(OFS_STAT, v); check("R11 detect wins", v & 32'h2, 32'h2);
    bus_wr(OFS_STAT, 32'h0000_0002);
    bus_rd(OFS_STAT, v); check("R7 one edge one set", v & 32'h2, 32'h0);
    pad_in = '0;
    settle();
    bus_rd(OFS_STAT, v); check("R7 falling ignored in rise mode", v & 32'h2, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule